// File: doc/BRIEF.md
# Tile-mode VRAM address and colour generator

This block turns one character cell of a tiled display into a row of pixel colour codes. For each cell request it takes the display mode, the three table base registers, the text colour register, the cell column and row, and the pixel row inside the cell. It then reads the name byte, the pattern byte and, where the mode needs one, the colour byte from video memory one after another. From these bytes it produces up to eight 4-bit colour codes, with pixel 0 as the leftmost pixel.

Four modes are handled. Mode code 0 is 40-column text and code 1 is 32-column text. Code 2 is bitmap-style graphics, with the screen split into three bands of eight cell rows. Code 3 is low-resolution multicolour. Memory reads use a request/acknowledge pair. The request and address stay constant until the acknowledge, and read data is taken in the acknowledge cycle. Colour code 0 stands for transparent. A per-pixel opaque mask marks the other codes, so later stages can let the background show through.

Top module: `tile_colour_gen`

## Requirements
- R1: The first read of every cell is at address `{reg_name,10'b0} + index`. The index is `row*40+col` in mode 0 and `row*32+col` in the other modes. Reads always go in the order name, pattern, colour.
- R2: In modes 0 and 1 the pattern address is `{reg_pattern[2:0], code[7:0], pix_row[2:0]}`.
- R3: In mode 2 the band is `row[4:3]`. The pattern address is `{reg_pattern[2], band & reg_pattern[1:0], code, pix_row}` and the colour address is `{reg_colour[7], band & reg_colour[6:5], code, pix_row}`.
- R4: In mode 1 the colour address is `{reg_colour[7:0], 1'b0, code[7:3]}`, so one byte serves eight consecutive codes.
- R5: In mode 3 the pattern address is `{reg_pattern[2:0], code, row[1:0], pix_row[2]}`. There is no colour read in mode 3 or in mode 0, so a cell takes exactly two reads.
- R6: In mode 0 the output has `pix_count` = 6. Pixel i (0..5) shows pattern bit 7-i. A 1 bit gives `reg_text_col[7:4]` and a 0 bit gives `reg_text_col[3:0]`. Pixels 6 and 7 carry code 0.
- R7: In modes 1 and 2 the output has `pix_count` = 8. Pixel i shows pattern bit 7-i. A 1 bit gives the colour byte's high nibble and a 0 bit gives its low nibble.
- R8: In mode 3 the output has `pix_count` = 8. Pixels 0..3 take pattern bits 7:4 and pixels 4..7 take pattern bits 3:0.
- R9: `pix_opaque[i]` is 1 exactly when pixel i's code is not zero.
- R10: Once raised, `vram_rd_req` stays high with an unchanged `vram_addr` until the cycle in which `vram_rd_ack` is high. Data is taken in that cycle.
- R11: A `cell_start` seen while `cell_busy` is low captures all cell inputs. `cell_busy` then stays high until `pix_valid`, which lasts one cycle. A `cell_start` seen while busy is ignored and produces no extra result.
- R12: During reset `cell_busy`, `vram_rd_req` and `pix_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_start | input | 1 | Begin a cell when idle |
| disp_mode | input | 2 | 0 text40, 1 text32, 2 graphics, 3 multicolour |
| reg_name | input | 4 | Name table base, address bits 13:10 |
| reg_colour | input | 8 | Colour table base, address bits 13:6 |
| reg_pattern | input | 3 | Pattern table base, address bits 13:11 |
| reg_text_col | input | 8 | Text colours: high nibble for 1 pixels, low nibble for 0 pixels |
| cell_col | input | 6 | Cell column |
| cell_row | input | 5 | Cell row, 0..23 |
| pix_row | input | 3 | Pixel row inside the cell |
| cell_busy | output | 1 | A cell is in progress |
| vram_rd_req | output | 1 | Memory read request |
| vram_addr | output | 14 | Memory read address |
| vram_rd_ack | input | 1 | Read accepted, data valid |
| vram_rd_data | input | 8 | Read data |
| pix_valid | output | 1 | One-cycle result strobe |
| pix_count | output | 4 | Number of displayed pixels (6 or 8) |
| pix_colour | output | 32 | Pixel i code at bits 4i+3:4i |
| pix_opaque | output | 8 | Per-pixel non-zero flag |

## Verification
Cells are tried in every mode at the first and last screen positions and in mid-screen cells. This separates the 40-wide and 32-wide name indexing and checks the last text index, 959. Graphics cells in all three bands, with fully set and with partly cleared base bits, distinguish correct band masking from plain base placement. Multicolour cells on different rows and pixel rows expose the byte-pair selection. Read latencies of zero to three cycles separate correct hold-until-acknowledge behaviour from a sequencer that assumes fixed timing. A text colour register with a zero nibble shows the transparency mask.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  localparam int ADDR_W    = 14;
  localparam int DATA_W    = 8;
  localparam int COLOR_W   = 4;
  localparam int CELL_PX   = 8;
  localparam int NARROW_PX = 6;
  localparam int COL_W     = 6;
  localparam int ROW_W     = 5;
  localparam int PROW_W    = 3;
  localparam int IDX_W     = 10;
  localparam int WIDE_COLS = 40;
  localparam int CNT_W     = 4;

  typedef enum logic [1:0] {
    MODE_T40 = 2'd0,
    MODE_T32 = 2'd1,
    MODE_GFX = 2'd2,
    MODE_MC  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    PH_NAME = 2'd0,
    PH_PAT  = 2'd1,
    PH_COL  = 2'd2
  } phase_e;
endpackage

// File: rtl/tcg_addr_gen.sv
module tcg_addr_gen
  import tcg_pkg::*;
(
  input  mode_e               mode,
  input  phase_e              phase,
  input  logic [3:0]          base_name,
  input  logic [7:0]          base_colour,
  input  logic [2:0]          base_pattern,
  input  logic [COL_W-1:0]    col,
  input  logic [ROW_W-1:0]    row,
  input  logic [PROW_W-1:0]   prow,
  input  logic [DATA_W-1:0]   code,
  output logic [ADDR_W-1:0]   addr
);
  logic [IDX_W-1:0]  idx;
  logic [1:0]        band;
  logic [ADDR_W-1:0] name_addr;
  logic [ADDR_W-1:0] pat_addr;
  logic [ADDR_W-1:0] col_addr;

  assign band = row[ROW_W-1:ROW_W-2];

  always_comb begin
    if (mode == MODE_T40)
      idx = IDX_W'(row) * IDX_W'(WIDE_COLS) + IDX_W'(col);
    else
      idx = {row, col[4:0]};
    name_addr = ADDR_W'({base_name, {IDX_W{1'b0}}}) + ADDR_W'(idx);
  end

  always_comb begin
    case (mode)
      MODE_GFX: pat_addr = {base_pattern[2], band & base_pattern[1:0], code, prow};
      MODE_MC:  pat_addr = {base_pattern, code, row[1:0], prow[2]};
      default:  pat_addr = {base_pattern, code, prow};
    endcase
    if (mode == MODE_GFX)
      col_addr = {base_colour[7], band & base_colour[6:5], code, prow};
    else
      col_addr = {base_colour, 1'b0, code[DATA_W-1:3]};
  end

  always_comb begin
    case (phase)
      PH_PAT:  addr = pat_addr;
      PH_COL:  addr = col_addr;
      default: addr = name_addr;
    endcase
  end
endmodule

// File: rtl/tcg_pix_mux.sv
module tcg_pix_mux
  import tcg_pkg::*;
(
  input  mode_e                        mode,
  input  logic [DATA_W-1:0]            pat,
  input  logic [DATA_W-1:0]            colr,
  input  logic [DATA_W-1:0]            text_col,
  output logic [CELL_PX*COLOR_W-1:0]   colours,
  output logic [CELL_PX-1:0]           opaque,
  output logic [CNT_W-1:0]             count
);
  localparam int HALF_PX = CELL_PX / 2;

  genvar i;
  generate
    for (i = 0; i < CELL_PX; i++) begin : g_px
      logic             bit_on;
      logic [COLOR_W-1:0] c;
      assign bit_on = pat[DATA_W-1-i];
      always_comb begin
        case (mode)
          MODE_T40: c = (i < NARROW_PX) ? (bit_on ? text_col[7:4] : text_col[3:0]) : '0;
          MODE_MC:  c = (i < HALF_PX) ? pat[7:4] : pat[3:0];
          default:  c = bit_on ? colr[7:4] : colr[3:0];
        endcase
      end
      assign colours[i*COLOR_W +: COLOR_W] = c;
      assign opaque[i] = |c;
    end
  endgenerate

  assign count = (mode == MODE_T40) ? CNT_W'(NARROW_PX) : CNT_W'(CELL_PX);
endmodule

// File: rtl/tcg_fetch_seq.sv
module tcg_fetch_seq
  import tcg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   needs_colour,
  input  logic   ack,
  output logic   busy,
  output logic   req,
  output phase_e phase,
  output logic   load_cell,
  output logic   cap_name,
  output logic   cap_pat,
  output logic   cap_col,
  output logic   out_valid
);
  typedef enum logic [2:0] {S_IDLE, S_NAME, S_PAT, S_COL, S_OUT} state_e;
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (start) state_d = S_NAME;
      S_NAME: if (ack) state_d = S_PAT;
      S_PAT:  if (ack) state_d = needs_colour ? S_COL : S_OUT;
      S_COL:  if (ack) state_d = S_OUT;
      S_OUT:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    case (state_q)
      S_PAT:   phase = PH_PAT;
      S_COL:   phase = PH_COL;
      default: phase = PH_NAME;
    endcase
  end

  assign busy      = (state_q != S_IDLE);
  assign req       = (state_q == S_NAME) || (state_q == S_PAT) || (state_q == S_COL);
  assign load_cell = (state_q == S_IDLE) && start;
  assign cap_name  = (state_q == S_NAME) && ack;
  assign cap_pat   = (state_q == S_PAT) && ack;
  assign cap_col   = (state_q == S_COL) && ack;
  assign out_valid = (state_q == S_OUT);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req);
  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
endmodule

// File: rtl/tile_colour_gen.sv
module tile_colour_gen
  import tcg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cell_start,
  input  logic [1:0]                  disp_mode,
  input  logic [3:0]                  reg_name,
  input  logic [7:0]                  reg_colour,
  input  logic [2:0]                  reg_pattern,
  input  logic [7:0]                  reg_text_col,
  input  logic [COL_W-1:0]            cell_col,
  input  logic [ROW_W-1:0]            cell_row,
  input  logic [PROW_W-1:0]           pix_row,
  output logic                        cell_busy,
  output logic                        vram_rd_req,
  output logic [ADDR_W-1:0]           vram_addr,
  input  logic                        vram_rd_ack,
  input  logic [DATA_W-1:0]           vram_rd_data,
  output logic                        pix_valid,
  output logic [CNT_W-1:0]            pix_count,
  output logic [CELL_PX*COLOR_W-1:0]  pix_colour,
  output logic [CELL_PX-1:0]          pix_opaque
);
  mode_e              mode_q;
  logic [3:0]         name_q;
  logic [7:0]         colb_q;
  logic [2:0]         patb_q;
  logic [7:0]         text_q;
  logic [COL_W-1:0]   col_q;
  logic [ROW_W-1:0]   row_q;
  logic [PROW_W-1:0]  prow_q;
  logic [DATA_W-1:0]  code_q, pat_q, colr_q;

  phase_e phase;
  logic   load_cell, cap_name, cap_pat, cap_col, needs_colour;

  assign needs_colour = (mode_q == MODE_T32) || (mode_q == MODE_GFX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_T40;
      name_q <= '0;
      colb_q <= '0;
      patb_q <= '0;
      text_q <= '0;
      col_q  <= '0;
      row_q  <= '0;
      prow_q <= '0;
    end else if (load_cell) begin
      mode_q <= mode_e'(disp_mode);
      name_q <= reg_name;
      colb_q <= reg_colour;
      patb_q <= reg_pattern;
      text_q <= reg_text_col;
      col_q  <= cell_col;
      row_q  <= cell_row;
      prow_q <= pix_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pat_q  <= '0;
      colr_q <= '0;
    end else begin
      if (cap_name) code_q <= vram_rd_data;
      if (cap_pat)  pat_q  <= vram_rd_data;
      if (cap_col)  colr_q <= vram_rd_data;
    end
  end

  tcg_fetch_seq i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (cell_start),
    .needs_colour (needs_colour),
    .ack          (vram_rd_ack),
    .busy         (cell_busy),
    .req          (vram_rd_req),
    .phase        (phase),
    .load_cell    (load_cell),
    .cap_name     (cap_name),
    .cap_pat      (cap_pat),
    .cap_col      (cap_col),
    .out_valid    (pix_valid)
  );

  tcg_addr_gen i_addr (
    .mode         (mode_q),
    .phase        (phase),
    .base_name    (name_q),
    .base_colour  (colb_q),
    .base_pattern (patb_q),
    .col          (col_q),
    .row          (row_q),
    .prow         (prow_q),
    .code         (code_q),
    .addr         (vram_addr)
  );

  tcg_pix_mux i_pix (
    .mode     (mode_q),
    .pat      (pat_q),
    .colr     (colr_q),
    .text_col (text_q),
    .colours  (pix_colour),
    .opaque   (pix_opaque),
    .count    (pix_count)
  );

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd_req && !vram_rd_ack |=> $stable(vram_addr));
  // R6
  narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && (mode_q == MODE_T40) |-> (pix_opaque[7:6] == 2'b00) && (pix_count == CNT_W'(NARROW_PX)));
endmodule

// File: tb/test_tile_colour_gen.sv
`timescale 1ns/1ps
module test_tile_colour_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cell_start;
  logic [1:0]  disp_mode;
  logic [3:0]  reg_name;
  logic [7:0]  reg_colour;
  logic [2:0]  reg_pattern;
  logic [7:0]  reg_text_col;
  logic [5:0]  cell_col;
  logic [4:0]  cell_row;
  logic [2:0]  pix_row;
  logic        cell_busy, vram_rd_req, vram_rd_ack, pix_valid;
  logic [13:0] vram_addr;
  logic [7:0]  vram_rd_data;
  logic [3:0]  pix_count;
  logic [31:0] pix_colour;
  logic [7:0]  pix_opaque;

  always #4 clk = ~clk;

  tile_colour_gen i_tile_colour_gen (
    .clk(clk), .rst_n(rst_n), .cell_start(cell_start), .disp_mode(disp_mode),
    .reg_name(reg_name), .reg_colour(reg_colour), .reg_pattern(reg_pattern),
    .reg_text_col(reg_text_col), .cell_col(cell_col), .cell_row(cell_row),
    .pix_row(pix_row), .cell_busy(cell_busy), .vram_rd_req(vram_rd_req),
    .vram_addr(vram_addr), .vram_rd_ack(vram_rd_ack), .vram_rd_data(vram_rd_data),
    .pix_valid(pix_valid), .pix_count(pix_count), .pix_colour(pix_colour),
    .pix_opaque(pix_opaque)
  );

  function automatic logic [7:0] vbyte(input logic [13:0] a);
    logic [15:0] t;
    t = {2'b00, a} * 16'd157 + 16'h3B;
    return t[11:4] ^ a[7:0];
  endfunction

  // memory model: acknowledge after lat waiting cycles
  int unsigned lat = 0;
  int unsigned gap = 0;
  assign vram_rd_ack  = vram_rd_req && (gap >= lat);
  assign vram_rd_data = vbyte(vram_addr);
  always @(posedge clk) begin
    if (vram_rd_req && !vram_rd_ack) gap <= gap + 1;
    else gap <= 0;
  end

  int n_chk = 0, n_fail = 0;
  logic [13:0] log_addr [4];
  int log_n = 0;
  int n_valid = 0;
  int stall_bad = 0;
  logic prev_stall = 1'b0;
  logic [13:0] prev_addr = '0;

  always @(negedge clk) begin
    if (prev_stall && (!vram_rd_req || vram_addr !== prev_addr)) stall_bad++;
    prev_stall = vram_rd_req && !vram_rd_ack;
    prev_addr  = vram_addr;
    if (vram_rd_req && vram_rd_ack) begin
      if (log_n < 4) log_addr[log_n] = vram_addr;
      log_n++;
    end
    if (pix_valid) n_valid++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // fields: mode, name, colour, pattern, text, col, row, prow, latency
  localparam int NV = 12;
  localparam logic [40:0] VEC [NV] = '{
    {2'd0, 4'h0, 8'h00, 3'd1, 8'hF4, 6'd0,  5'd0,  3'd0, 2'd0},
    {2'd0, 4'h0, 8'h00, 3'd1, 8'hF4, 6'd39, 5'd23, 3'd7, 2'd1},
    {2'd1, 4'h6, 8'h80, 3'd0, 8'h00, 6'd31, 5'd23, 3'd5, 2'd0},
    {2'd1, 4'h6, 8'h80, 3'd0, 8'h00, 6'd5,  5'd10, 3'd2, 2'd2},
    {2'd2, 4'h6, 8'hFF, 3'd7, 8'h00, 6'd3,  5'd0,  3'd1, 2'd0},
    {2'd2, 4'h6, 8'hFF, 3'd7, 8'h00, 6'd17, 5'd12, 3'd4, 2'd1},
    {2'd2, 4'h6, 8'hFF, 3'd7, 8'h00, 6'd31, 5'd23, 3'd7, 2'd0},
    {2'd2, 4'h6, 8'h7F, 3'd3, 8'h00, 6'd8,  5'd20, 3'd6, 2'd0},
    {2'd2, 4'h6, 8'h9F, 3'd4, 8'h00, 6'd7,  5'd20, 3'd3, 2'd3},
    {2'd3, 4'h2, 8'h00, 3'd0, 8'h00, 6'd4,  5'd1,  3'd3, 2'd0},
    {2'd3, 4'h2, 8'h00, 3'd0, 8'h00, 6'd9,  5'd6,  3'd6, 2'd3},
    {2'd0, 4'h1, 8'h00, 3'd2, 8'hF0, 6'd12, 5'd7,  3'd2, 2'd0}
  };

  task automatic drive(input logic [40:0] v);
    disp_mode    = v[40:39];
    reg_name     = v[38:35];
    reg_colour   = v[34:27];
    reg_pattern  = v[26:24];
    reg_text_col = v[23:16];
    cell_col     = v[15:10];
    cell_row     = v[9:5];
    pix_row      = v[4:2];
    lat          = v[1:0];
  endtask

  task automatic wait_valid();
    int k = 0;
    while (!pix_valid && k < 60) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic check_cell(input logic [40:0] v);
    logic [1:0]  m;
    logic [9:0]  idx;
    logic [13:0] na, pa, ca;
    logic [7:0]  code, pat, colr, tc;
    logic [1:0]  band;
    logic [31:0] ec;
    logic [7:0]  eo;
    logic [3:0]  c;
    int          nf;
    string       ptag, ctag, otag;
    m = v[40:39];
    tc = v[23:16];
    band = v[9:8];
    idx = (m == 2'd0) ? (10'(v[9:5]) * 10'd40 + 10'(v[15:10])) : {v[9:5], v[14:10]};
    na = {v[38:35], 10'b0} + 14'(idx);
    code = vbyte(na);
    case (m)
      2'd2: pa = {v[26], band & v[25:24], code, v[4:2]};
      2'd3: pa = {v[26:24], code, v[6:5], v[4]};
      default: pa = {v[26:24], code, v[4:2]};
    endcase
    if (m == 2'd2) ca = {v[34], band & v[33:32], code, v[4:2]};
    else           ca = {v[34:27], 1'b0, code[7:3]};
    pat = vbyte(pa);
    colr = vbyte(ca);
    nf = (m == 2'd1 || m == 2'd2) ? 3 : 2;
    ptag = (m == 2'd2) ? "R3 pattern addr" : (m == 2'd3) ? "R5 pattern addr" : "R2 pattern addr";
    ctag = (m == 2'd2) ? "R3 colour addr" : "R4 colour addr";
    otag = (m == 2'd0) ? "R6 pixels" : (m == 2'd3) ? "R8 pixels" : "R7 pixels";
    for (int i = 0; i < 8; i++) begin
      case (m)
        2'd0: c = (i < 6) ? (pat[7-i] ? tc[7:4] : tc[3:0]) : 4'h0;
        2'd3: c = (i < 4) ? pat[7:4] : pat[3:0];
        default: c = pat[7-i] ? colr[7:4] : colr[3:0];
      endcase
      ec[i*4 +: 4] = c;
      eo[i] = (c != 4'h0);
    end
    chk("R5 fetch count", 32'(log_n), 32'(nf));
    chk("R1 name addr", 32'(log_addr[0]), 32'(na));
    chk(ptag, 32'(log_addr[1]), 32'(pa));
    if (nf == 3) chk(ctag, 32'(log_addr[2]), 32'(ca));
    chk(otag, 32'(pix_count), (m == 2'd0) ? 32'd6 : 32'd8);
    chk(otag, pix_colour, ec);
    chk("R9 opaque mask", 32'(pix_opaque), 32'(eo));
  endtask

  task automatic run_cell(input logic [40:0] v);
    @(negedge clk);
    drive(v);
    log_n = 0;
    cell_start = 1'b1;
    @(negedge clk);
    cell_start = 1'b0;
    wait_valid();
    check_cell(v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cell_start = 1'b0;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    // R12: idle outputs under reset
    chk("R12 busy in reset", 32'(cell_busy), 32'd0);
    chk("R12 req in reset", 32'(vram_rd_req), 32'd0);
    chk("R12 valid in reset", 32'(pix_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) run_cell(VEC[n]);

    // R10: request held steady through every stall seen so far
    chk("R10 stall stability", 32'(stall_bad), 32'd0);

    // R11: start pulses during a busy cell are ignored
    @(negedge clk);
    drive(VEC[3]);
    lat = 3;
    log_n = 0;
    n_valid = 0;
    cell_start = 1'b1;
    @(negedge clk);
    chk("R11 busy after start", 32'(cell_busy), 32'd1);
    drive(VEC[9]);
    lat = 3;
    repeat (2) @(negedge clk);
    cell_start = 1'b0;
    wait_valid();
    check_cell(VEC[3]);
    repeat (20) @(negedge clk);
    chk("R11 single result", 32'(n_valid), 32'd1);
    chk("R11 idle after result", 32'(cell_busy), 32'd0);
    chk("R10 stall stability", 32'(stall_bad), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule